// File: doc/BRIEF.md
# Bit-Tree Peripheral ID Lookup

This block turns a peripheral identifier into an interrupt-slot index. The identifier is 12 bits wide, made from a 4-bit slave number in the upper bits and an 8-bit peripheral number in the lower bits. The translation is done by walking a binary decision tree kept in an on-chip table of 32-bit node words. Each node names one identifier bit to test. For each value of that bit, the node gives either the index of the next node or a final slot number. The walk visits one node per clock.

A found slot is then checked against a per-slot owner table, which must match the configured environment ID. It is also checked against a per-slot cache that remembers which identifier each slot was first bound to. A fresh binding updates the lowest and highest slot ever bound. The highest value only moves for slots below a configurable interrupt-slot limit. The node table and the owner table are loaded through plain write ports.

Requests use a valid/ready handshake. `req_ready` is high only when the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A request presented while the block is busy is not taken. The result comes back as a one-cycle `res_done` pulse and cannot be stalled. The result fields hold their value until the next result.

Top module: `ptree_lookup`

## Requirements
- R1: The key is {req_sid, req_pid}, with the slave number in key bits [11:8]. A node tests key bit node[21:18], and a bit index of 12 to 15 tests a zero. A tested 1 selects the one-branch, and a tested 0 selects the zero-branch.
- R2: In the zero-branch, node bit 17 is the continue flag and node[16:9] is the value. In the one-branch, node bit 8 is the continue flag and node[7:0] is the value. A set flag makes the value the next node index. A clear flag makes the value the final slot, and the walk ends.
- R3: The walk starts at node 0 and visits at most MAX_DEPTH nodes. If the walk is still continuing after the last of them, the result is not-found with res_slot = 256.
- R4: A walk that reaches node index 255 or above ends at that step as not-found (res_slot = 256). That index is never read from the table.
- R5: A final slot is accepted only if its owner entry equals ee_id. Otherwise the result is not-found (res_found = 0, res_slot = 256).
- R6: An accepted slot with no cached binding is bound to the key. An accepted slot already bound to the same key is returned unchanged. In both cases res_found = 1 and res_slot is the slot number.
- R7: An accepted slot already bound to a different key gives res_conflict = 1, res_found = 0 and res_slot = 256. The cache and the slot range are left unchanged.
- R8: On each fresh binding, min_slot takes the slot number if the slot is lower. max_slot takes the slot number only if the slot is higher and below INTR_LIMIT.
- R9: req_ready is low from the accepting edge until res_done has been shown. A request presented during that time is not taken. res_done is high for exactly one cycle.
- R10: After reset, req_ready = 1, res_done = 0, min_slot = 255, max_slot = 0, and all slot bindings are empty.
- R11: If the walk ends with a slot at node visit n, res_done is high n+1 cycles after the accepting edge. If the walk fails at visit n, res_done is high n cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_id | input | 3 | Environment ID that owner entries must match |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | High when idle and able to take a request |
| req_sid | input | 4 | Slave number (key bits 11:8) |
| req_pid | input | 8 | Peripheral number (key bits 7:0) |
| node_we | input | 1 | Node table write enable |
| node_waddr | input | 8 | Node table write index |
| node_wdata | input | 32 | Node word |
| owner_we | input | 1 | Owner table write enable |
| owner_waddr | input | 8 | Owner table slot |
| owner_wdata | input | 3 | Owner value |
| res_done | output | 1 | One-cycle result strobe |
| res_slot | output | 9 | Slot number, or 256 when not found |
| res_found | output | 1 | Lookup succeeded |
| res_conflict | output | 1 | Slot already bound to another key |
| min_slot | output | 8 | Lowest slot ever bound |
| max_slot | output | 8 | Highest bound slot below INTR_LIMIT |

## Verification
The bench builds the block with INTR_LIMIT = 64. This makes it possible to bind a slot (70) that must not raise max_slot while lower slots still do. MAX_DEPTH stays at 16 and the node table stays at 255 entries, so a self-looping node runs the full sixteen-visit limit and a branch to node 255 hits the range guard. A behavioural model predicts the slot, the flags and the exact cycle of res_done, and the bench compares the outputs to it on every clock of each lookup. The tree and the owner entries are rewritten between lookups to reach each branch kind, the ownership rejection, the rebind conflict, and a request made while busy.

// File: rtl/ptree_pkg.sv
package ptree_pkg;
  localparam int SEL_W  = 4;
  localparam int VAL_W  = 8;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [9:0]       spare;
    logic [SEL_W-1:0] bit_sel;
    logic             zero_cont;
    logic [VAL_W-1:0] zero_val;
    logic             one_cont;
    logic [VAL_W-1:0] one_val;
  } node_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_CHECK = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_t;
endpackage

// File: rtl/ptree_node_ram.sv
module ptree_node_ram #(
  parameter int DEPTH = 255,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < DEPTH) rdata = mem[raddr];
  end
endmodule

// File: rtl/ptree_owner_ram.sv
module ptree_owner_ram #(
  parameter int SLOTS = 256,
  parameter int AW    = 8,
  parameter int OW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [OW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [OW-1:0] rdata
);
  logic [OW-1:0] own_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) own_q[i] <= '0;
    end else if (we) begin
      own_q[waddr] <= wdata;
    end
  end

  assign rdata = own_q[raddr];
endmodule

// File: rtl/ptree_slot_cache.sv
module ptree_slot_cache #(
  parameter int SLOTS = 256,
  parameter int AW    = 8,
  parameter int KW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [KW-1:0] wkey,
  input  logic [AW-1:0] raddr,
  output logic          rvalid,
  output logic [KW-1:0] rkey
);
  logic [SLOTS-1:0] valid_q;
  logic [KW-1:0]    key_mem [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (we) valid_q[waddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) key_mem[waddr] <= wkey;
  end

  assign rvalid = valid_q[raddr];
  assign rkey   = key_mem[raddr];

  // a binding is only ever created for an empty slot
  assert_fresh_bind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !valid_q[waddr]);
endmodule

// File: rtl/ptree_range_track.sv
module ptree_range_track #(
  parameter int AW         = 8,
  parameter int INTR_LIMIT = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [AW-1:0] slot,
  output logic [AW-1:0] min_q,
  output logic [AW-1:0] max_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '1;
      max_q <= '0;
    end else if (upd) begin
      if (slot < min_q) min_q <= slot;
      if ((int'(slot) < INTR_LIMIT) && (slot > max_q)) max_q <= slot;
    end
  end

  assert_min_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> min_q <= $past(min_q));
  assert_max_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(max_q) |-> int'(max_q) < INTR_LIMIT);
endmodule

// File: rtl/ptree_lookup.sv
module ptree_lookup
  import ptree_pkg::*;
#(
  parameter int SID_W      = 4,
  parameter int PID_W      = 8,
  parameter int OWNER_W    = 3,
  parameter int NODE_CNT   = 255,
  parameter int MAX_DEPTH  = 16,
  parameter int INTR_LIMIT = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OWNER_W-1:0] ee_id,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SID_W-1:0]   req_sid,
  input  logic [PID_W-1:0]   req_pid,
  input  logic               node_we,
  input  logic [VAL_W-1:0]   node_waddr,
  input  logic [WORD_W-1:0]  node_wdata,
  input  logic               owner_we,
  input  logic [VAL_W-1:0]   owner_waddr,
  input  logic [OWNER_W-1:0] owner_wdata,
  output logic               res_done,
  output logic [VAL_W:0]     res_slot,
  output logic               res_found,
  output logic               res_conflict,
  output logic [VAL_W-1:0]   min_slot,
  output logic [VAL_W-1:0]   max_slot
);
  localparam int KEY_W     = SID_W + PID_W;
  localparam int EXT_W     = 1 << SEL_W;
  localparam int SLOT_CNT  = 1 << VAL_W;
  localparam int STEP_W    = $clog2(MAX_DEPTH + 1);
  localparam logic [VAL_W:0] NOT_FOUND = (VAL_W+1)'(SLOT_CNT);

  walk_state_t        state_q;
  logic [KEY_W-1:0]   key_q;
  logic [VAL_W-1:0]   idx_q;
  logic [STEP_W-1:0]  step_q;
  logic [VAL_W-1:0]   slot_q;
  logic [VAL_W:0]     res_slot_q;
  logic               found_q, conflict_q;

  logic [WORD_W-1:0]  node_raw;
  node_t              node;
  logic [EXT_W-1:0]   key_ext;
  logic               tbit, br_cont, idx_bad;
  logic [VAL_W-1:0]   br_val;
  logic [OWNER_W-1:0] owner_rd;
  logic               c_valid;
  logic [KEY_W-1:0]   c_key;
  logic               owner_ok, bind_new;

  ptree_node_ram #(.DEPTH(NODE_CNT), .AW(VAL_W), .DW(WORD_W)) u_nodes (
    .clk(clk), .we(node_we), .waddr(node_waddr), .wdata(node_wdata),
    .raddr(idx_q), .rdata(node_raw));

  ptree_owner_ram #(.SLOTS(SLOT_CNT), .AW(VAL_W), .OW(OWNER_W)) u_owner (
    .clk(clk), .rst_n(rst_n), .we(owner_we), .waddr(owner_waddr),
    .wdata(owner_wdata), .raddr(slot_q), .rdata(owner_rd));

  ptree_slot_cache #(.SLOTS(SLOT_CNT), .AW(VAL_W), .KW(KEY_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .we(bind_new), .waddr(slot_q), .wkey(key_q),
    .raddr(slot_q), .rvalid(c_valid), .rkey(c_key));

  ptree_range_track #(.AW(VAL_W), .INTR_LIMIT(INTR_LIMIT)) u_range (
    .clk(clk), .rst_n(rst_n), .upd(bind_new), .slot(slot_q),
    .min_q(min_slot), .max_q(max_slot));

  // branch selection for the node under the cursor
  always_comb begin
    node    = node_t'(node_raw);
    key_ext = EXT_W'(key_q);
    tbit    = key_ext[node.bit_sel];
    br_cont = tbit ? node.one_cont : node.zero_cont;
    br_val  = tbit ? node.one_val  : node.zero_val;
    idx_bad = int'(idx_q) >= NODE_CNT;
  end

  assign owner_ok = (owner_rd == ee_id);
  assign bind_new = (state_q == ST_CHECK) && owner_ok && !c_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      key_q      <= '0;
      idx_q      <= '0;
      step_q     <= '0;
      slot_q     <= '0;
      res_slot_q <= NOT_FOUND;
      found_q    <= 1'b0;
      conflict_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            key_q   <= {req_sid, req_pid};
            idx_q   <= '0;
            step_q  <= '0;
            state_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (idx_bad) begin
            res_slot_q <= NOT_FOUND;
            found_q    <= 1'b0;
            conflict_q <= 1'b0;
            state_q    <= ST_RESP;
          end else if (!br_cont) begin
            slot_q  <= br_val;
            state_q <= ST_CHECK;
          end else if (step_q == STEP_W'(MAX_DEPTH - 1)) begin
            res_slot_q <= NOT_FOUND;
            found_q    <= 1'b0;
            conflict_q <= 1'b0;
            state_q    <= ST_RESP;
          end else begin
            idx_q  <= br_val;
            step_q <= step_q + 1'b1;
          end
        end
        ST_CHECK: begin
          state_q <= ST_RESP;
          if (!owner_ok) begin
            res_slot_q <= NOT_FOUND;
            found_q    <= 1'b0;
            conflict_q <= 1'b0;
          end else if (c_valid && (c_key != key_q)) begin
            res_slot_q <= NOT_FOUND;
            found_q    <= 1'b0;
            conflict_q <= 1'b1;
          end else begin
            res_slot_q <= {1'b0, slot_q};
            found_q    <= 1'b1;
            conflict_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign res_done     = (state_q == ST_RESP);
  assign res_slot     = res_slot_q;
  assign res_found    = found_q;
  assign res_conflict = conflict_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_nf_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_found) |-> res_slot == NOT_FOUND);
  assert_found_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_found) |-> res_slot < NOT_FOUND);
  assert_conflict_nf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_conflict) |-> !res_found);
  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WALK) |-> int'(step_q) < MAX_DEPTH);
  assert_found_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !owner_ok) |=> !res_found);
endmodule

// File: tb/sim_ptree_lookup.sv
`timescale 1ns/1ps
module sim_ptree_lookup;
  localparam int LIM   = 64;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ee_id = 3'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sid = '0;
  logic [7:0]  req_pid = '0;
  logic        node_we = 1'b0;
  logic [7:0]  node_waddr = '0;
  logic [31:0] node_wdata = '0;
  logic        owner_we = 1'b0;
  logic [7:0]  owner_waddr = '0;
  logic [2:0]  owner_wdata = '0;
  logic        res_done;
  logic [8:0]  res_slot;
  logic        res_found, res_conflict;
  logic [7:0]  min_slot, max_slot;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model state
  logic [31:0] node_m  [256];
  int          owner_m [256];
  bit          cval_m  [256];
  int          ckey_m  [256];
  int          min_m = 255;
  int          max_m = 0;

  always #2.5 clk = ~clk;

  ptree_lookup #(.INTR_LIMIT(LIM), .MAX_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ee_id(ee_id),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sid(req_sid), .req_pid(req_pid),
    .node_we(node_we), .node_waddr(node_waddr), .node_wdata(node_wdata),
    .owner_we(owner_we), .owner_waddr(owner_waddr), .owner_wdata(owner_wdata),
    .res_done(res_done), .res_slot(res_slot), .res_found(res_found),
    .res_conflict(res_conflict), .min_slot(min_slot), .max_slot(max_slot));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int bs, input bit c0, input int v0,
                                     input bit c1, input int v1);
    logic [3:0] b = bs[3:0];
    logic [7:0] a = v0[7:0];
    logic [7:0] o = v1[7:0];
    return {10'b0, b, c0, a, c1, o};
  endfunction

  task automatic wr_node(input int idx, input logic [31:0] w);
    @(negedge clk);
    node_we = 1'b1; node_waddr = idx[7:0]; node_wdata = w;
    @(negedge clk);
    node_we = 1'b0;
    node_m[idx] = w;
  endtask

  task automatic wr_owner(input int slot, input int o);
    @(negedge clk);
    owner_we = 1'b1; owner_waddr = slot[7:0]; owner_wdata = o[2:0];
    @(negedge clk);
    owner_we = 1'b0;
    owner_m[slot] = o;
  endtask

  // predicts result and latency, and applies the binding to the model
  task automatic predict(input int key, output int lat, output int slot,
                         output bit f, output bit cf);
    int idx = 0;
    lat = DEPTH; slot = 256; f = 0; cf = 0;
    for (int s = 1; s <= DEPTH; s++) begin
      logic [31:0] w;
      int bs, val;
      bit b, cont;
      if (idx >= 255) begin lat = s; return; end
      w = node_m[idx];
      bs = int'(w[21:18]);
      b = (bs < 12) ? key[bs] : 1'b0;
      cont = b ? w[8] : w[17];
      val = b ? int'(w[7:0]) : int'(w[16:9]);
      if (!cont) begin
        lat = s + 1;
        if (owner_m[val] != int'(ee_id)) return;
        if (cval_m[val] && ckey_m[val] != key) begin cf = 1; return; end
        f = 1; slot = val;
        if (!cval_m[val]) begin
          cval_m[val] = 1; ckey_m[val] = key;
          if (val < min_m) min_m = val;
          if (val < LIM && val > max_m) max_m = val;
        end
        return;
      end
      idx = val;
    end
  endtask

  task automatic lookup(input int sid, input int pid, input string req, input bit poke);
    int lat, eslot;
    bit ef, ecf;
    predict((sid << 8) | pid, lat, eslot, ef, ecf);
    @(negedge clk);
    chk("R9", "ready before request", int'(req_ready), 1);
    req_sid = sid[3:0]; req_pid = pid[7:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= lat + 3; c++) begin
      if (poke && c == 1) begin
        req_valid = 1'b1; req_sid = ~sid[3:0]; req_pid = ~pid[7:0];
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk((c == lat) ? "R11" : "R9", "done", int'(res_done), int'(c == lat));
      if (c < lat) chk("R9", "ready while busy", int'(req_ready), 0);
      if (c > lat) chk("R9", "ready after result", int'(req_ready), 1);
      if (c == lat) begin
        chk(req, "slot", int'(res_slot), eslot);
        chk(req, "found", int'(res_found), int'(ef));
        chk(req, "conflict", int'(res_conflict), int'(ecf));
      end
    end
    chk("R8", "min_slot", int'(min_slot), min_m);
    chk("R8", "max_slot", int'(max_slot), max_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      node_m[i] = '0; owner_m[i] = 0; cval_m[i] = 0; ckey_m[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "ready", int'(req_ready), 1);
    chk("R10", "done", int'(res_done), 0);
    chk("R10", "min_slot", int'(min_slot), 255);
    chk("R10", "max_slot", int'(max_slot), 0);

    // tree: node0 tests bit 11, node1 bit 0, node2 bit 4
    wr_node(0, mk(11, 1, 1, 0, 5));
    wr_node(1, mk(0, 0, 10, 1, 2));
    wr_node(2, mk(4, 0, 70, 0, 20));
    wr_owner(5, 2); wr_owner(10, 2); wr_owner(70, 2);
    wr_owner(20, 1); wr_owner(3, 2);

    lookup(8, 0, "R1", 0);          // slave msb set: one-branch terminal 5
    lookup(0, 0, "R2", 0);          // continue to node1, terminal 10
    lookup(0, 0, "R6", 0);          // same key again: unchanged slot 10
    lookup(0, 2, "R7", 0);          // different key to slot 10: conflict
    lookup(0, 1, "R8", 0);          // slot 70 above limit: max stays
    lookup(0, 8'h11, "R5", 0);      // slot 20 owned by another env
    lookup(0, 8'h11, "R1", 1);      // busy request not taken (R9)
    ee_id = 3'd1;
    lookup(0, 8'h11, "R5", 0);      // owner now matches, max becomes 20
    ee_id = 3'd2;

    // R3: node 0 loops to itself on both branches
    wr_node(0, mk(0, 1, 0, 1, 0));
    lookup(1, 2, "R3", 0);
    // R4: one-branch continues to index 255, zero-branch ends at slot 3
    wr_node(0, mk(11, 0, 3, 1, 255));
    lookup(8, 1, "R4", 0);
    lookup(2, 1, "R8", 0);          // slot 3 lowers min
    // R1: bit index 14 reads as zero
    wr_node(0, mk(14, 0, 5, 0, 10));
    lookup(15, 255, "R1", 0);       // conflict at slot 5 shows zero-branch taken

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule